// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Protocol Checker

This block watches the command pins of a DDR SDRAM from the device side. On every rising clock edge it samples chip select, the three strobes (row, column, write), clock enable, two bank-select bits and a 12-bit address. It decodes a command and shows it one cycle later. It keeps the two mode registers, a DLL-enable flag, and a small record for each of the four banks: whether the bank is open, how many cycles have passed since it was activated, and whether a self-timed precharge is pending.

Each command is checked against the bank record. A command that breaks a rule has no effect on state. It raises a violation flag with a 3-bit cause code in the same cycle as the decoded command. A read with auto-precharge is accepted from tRCD(min) cycles after activation onward. The block then times the internal precharge itself. The precharge starts half a burst after the read, or at tRAS(min) from activation if that is later. A one-cycle pulse per bank marks the start.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With chip select low and clock enable high, the strobe levels (row, column, write) decode on `cmd_o` as: L L L with bank bits 00 = 1 (mode write), with bank bits 01 = 2 (extended mode write), with other bank bits = 0; L L H = 3 (refresh, bank and address ignored); L H H = 4 (activate); H L L = 7 (write); H L H = 5 (read), or 6 when address bit 10 is high (read with auto-precharge); L H L = 8 (precharge one bank), or 9 when address bit 10 is high (precharge all); H H L = 10 (burst stop); H H H = 0 (no-operation).
- R2: A cycle with chip select high, or with clock enable low, decodes as 0, changes no state and raises no violation, whatever the other pins carry.
- R3: A mode write loads all 12 address bits into `mode_reg_o` and sets `mode_valid_o`, but only when no bank is open or waiting for its internal precharge. Otherwise the register is left unchanged and cause 1 is reported.
- R4: An extended mode write is accepted in any bank state. It loads `ext_mode_o` and sets `ext_valid_o`. `dll_en_o` is high while the stored bit 0 is low.
- R5: Mode bits 2..0 set the burst length: 1 gives 2, 2 gives 4, 3 gives 8, and any other code gives 2. After an accepted read on edge r, a burst stop on edges r+1 to r+BL/2 is legal and ends the burst. A burst stop at any other time reports cause 2.
- R6: An activate opens an idle bank and starts counting cycles for that bank from 1. An activate to a bank that is already open is ignored and raises no violation.
- R7: A read or write to an idle bank reports cause 5. A read or write issued n cycles after activation, with n < tRCD, reports cause 3. Neither changes any state.
- R8: A read with auto-precharge on edge r, issued n cycles after activation, starts the internal precharge on edge r+max(BL/2, tRAS−n). `iprech_o` for that bank is high for the one cycle after that edge, and the bank is idle from then on.
- R9: While a bank waits for its internal precharge (edges r+1 through the start edge), any activate, read, write or precharge to it reports cause 4 and has no effect. A precharge-all while any bank is waiting also reports cause 4.
- R10: A single-bank precharge closes the selected bank. A precharge-all closes every bank. A precharge to an idle bank raises no violation.
- R11: `viol_o` and the cause on `viol_cause_o` appear in the same cycle as the offending command on `cmd_o` and clear on the next clean command. No-operation, refresh and extended mode writes never raise a violation.
- R12: After reset all banks are idle, both register-valid flags and `dll_en_o` are low, `cmd_o` is 0, and no violation or precharge pulse is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select |
| addr | input | AW (12) | Address / register data |
| cmd_o | output | 4 | Decoded command of the previous edge |
| mode_reg_o | output | AW | Mode register contents |
| mode_valid_o | output | 1 | Mode register written since reset |
| ext_mode_o | output | AW | Extended mode register contents |
| ext_valid_o | output | 1 | Extended mode register written since reset |
| dll_en_o | output | 1 | DLL enabled |
| viol_o | output | 1 | Protocol violation on the shown command |
| viol_cause_o | output | 3 | Violation cause, 0 when none |
| iprech_o | output | 4 | Per-bank internal precharge start pulse |

## Verification
The main coincidence is an internal precharge that starts on the same edge as a new command. The bench provokes it with an activate to a different bank on the start edge. It expects the activate to be accepted and the precharge pulse to appear together in the next cycle. It also sends a write to the same bank on that edge and expects cause 4 alongside the pulse. The start edge itself is swept arithmetically: for every burst length, read distances from tRCD to past tRAS are tried, and the bench expects the pulse exactly at max(BL/2, tRAS−n) edges after the read and nowhere else.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_EMRS = 4'd2,
        CMD_REF  = 4'd3,
        CMD_ACT  = 4'd4,
        CMD_RD   = 4'd5,
        CMD_RDA  = 4'd6,
        CMD_WR   = 4'd7,
        CMD_PRE  = 4'd8,
        CMD_PREA = 4'd9,
        CMD_BST  = 4'd10
    } cmd_e;

    typedef enum logic [2:0] {
        VC_NONE      = 3'd0,
        VC_MODE_BUSY = 3'd1,
        VC_BAD_STOP  = 3'd2,
        VC_EARLY     = 3'd3,
        VC_INTERRUPT = 3'd4,
        VC_IDLE_BANK = 3'd5
    } cause_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       cke,
    input  logic [1:0] ba,
    input  logic       a10,
    output cmd_e       cmd_o
);

    always_comb begin
        cmd_o = CMD_NOP;
        if (!cs_n && cke) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: begin
                    if (ba == 2'b00)      cmd_o = CMD_MRS;
                    else if (ba == 2'b01) cmd_o = CMD_EMRS;
                    else                  cmd_o = CMD_NOP;
                end
                3'b001: cmd_o = CMD_REF;
                3'b010: cmd_o = a10 ? CMD_PREA : CMD_PRE;
                3'b011: cmd_o = CMD_ACT;
                3'b100: cmd_o = CMD_WR;
                3'b101: cmd_o = a10 ? CMD_RDA : CMD_RD;
                3'b110: cmd_o = CMD_BST;
                default: cmd_o = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_i,
    input  logic          close_i,
    input  logic          sched_i,
    input  logic [CW-1:0] wait_i,
    output logic          active_o,
    output logic          pending_o,
    output logic          start_o,
    output logic [CW-1:0] age_o
);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] age;
        logic [CW-1:0] pend;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (open_i) begin
            st_d.active = 1'b1;
            st_d.age    = CW'(1);
        end else if (st_q.active && (st_q.age != '1)) begin
            st_d.age = st_q.age + 1'b1;
        end
        if (sched_i) begin
            st_d.pend = wait_i;
        end else if (st_q.pend != '0) begin
            st_d.pend = st_q.pend - 1'b1;
        end
        if (close_i || (st_q.pend == CW'(1))) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o  = st_q.active;
    assign pending_o = (st_q.pend != '0);
    assign start_o   = (st_q.pend == CW'(1));
    assign age_o     = st_q.age;

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
    import ddr_cmd_pkg::*;
#(
    parameter int TRCD = 3,
    parameter int TRAS = 7,
    parameter int AW   = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          cke,
    input  logic [1:0]    ba,
    input  logic [AW-1:0] addr,
    output logic [3:0]    cmd_o,
    output logic [AW-1:0] mode_reg_o,
    output logic          mode_valid_o,
    output logic [AW-1:0] ext_mode_o,
    output logic          ext_valid_o,
    output logic          dll_en_o,
    output logic          viol_o,
    output logic [2:0]    viol_cause_o,
    output logic [3:0]    iprech_o
);

    localparam int NB = 4;
    localparam int CW = $clog2(TRAS + 16);
    localparam logic [CW-1:0] TRCD_C = CW'(TRCD);
    localparam logic [CW-1:0] TRAS_C = CW'(TRAS);

    typedef struct packed {
        cmd_e          cmd;
        logic          viol;
        cause_e        cause;
        logic [AW-1:0] mode;
        logic          mode_ok;
        logic [AW-1:0] ext;
        logic          ext_ok;
        logic [CW-1:0] burst;
        logic [NB-1:0] iprech;
    } mon_t;

    mon_t r_d, r_q;
    cmd_e cmd;

    logic [NB-1:0] open_v, close_v, sched_v;
    logic [NB-1:0] active_v, pend_v, start_v;
    logic [CW-1:0] age_v [NB];
    logic [CW-1:0] wait_w, half_w, tgt_age;
    logic [CW:0]   reach_w;
    logic          tgt_act, tgt_pend, read_ok;

    ddr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .ba    (ba),
        .a10   (addr[10]),
        .cmd_o (cmd)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        ddr_bank_timer #(.CW(CW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_i    (open_v[g]),
            .close_i   (close_v[g]),
            .sched_i   (sched_v[g]),
            .wait_i    (wait_w),
            .active_o  (active_v[g]),
            .pending_o (pend_v[g]),
            .start_o   (start_v[g]),
            .age_o     (age_v[g])
        );
    end

    // Half burst length from mode bits 2..0 and the precharge delay
    always_comb begin
        unique case (r_q.mode[2:0])
            3'd2:    half_w = CW'(2);
            3'd3:    half_w = CW'(4);
            default: half_w = CW'(1);
        endcase
        tgt_act  = active_v[ba];
        tgt_pend = pend_v[ba];
        tgt_age  = age_v[ba];
        reach_w  = {1'b0, tgt_age} + {1'b0, half_w};
        if (reach_w >= {1'b0, TRAS_C}) wait_w = half_w;
        else                          wait_w = TRAS_C - tgt_age;
    end

    always_comb begin
        r_d        = r_q;
        r_d.cmd    = cmd;
        r_d.cause  = VC_NONE;
        r_d.iprech = start_v;
        open_v     = '0;
        close_v    = '0;
        sched_v    = '0;
        read_ok    = 1'b0;

        unique case (cmd)
            CMD_MRS: begin
                if (|active_v) begin
                    r_d.cause = VC_MODE_BUSY;
                end else begin
                    r_d.mode    = addr;
                    r_d.mode_ok = 1'b1;
                end
            end
            CMD_EMRS: begin
                r_d.ext    = addr;
                r_d.ext_ok = 1'b1;
            end
            CMD_ACT: begin
                if (tgt_pend)      r_d.cause = VC_INTERRUPT;
                else if (!tgt_act) open_v[ba] = 1'b1;
            end
            CMD_RD, CMD_RDA, CMD_WR: begin
                if (tgt_pend)               r_d.cause = VC_INTERRUPT;
                else if (!tgt_act)          r_d.cause = VC_IDLE_BANK;
                else if (tgt_age < TRCD_C)  r_d.cause = VC_EARLY;
                else begin
                    read_ok = (cmd != CMD_WR);
                    if (cmd == CMD_RDA) sched_v[ba] = 1'b1;
                end
            end
            CMD_PRE: begin
                if (tgt_pend) r_d.cause = VC_INTERRUPT;
                else          close_v[ba] = 1'b1;
            end
            CMD_PREA: begin
                if (|pend_v) r_d.cause = VC_INTERRUPT;
                else         close_v = '1;
            end
            CMD_BST: begin
                if (r_q.burst == '0) r_d.cause = VC_BAD_STOP;
            end
            default: ;
        endcase

        if (read_ok)                  r_d.burst = half_w;
        else if (cmd == CMD_BST)      r_d.burst = '0;
        else if (r_q.burst != '0)     r_d.burst = r_q.burst - 1'b1;

        r_d.viol = (r_d.cause != VC_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_o        = r_q.cmd;
    assign mode_reg_o   = r_q.mode;
    assign mode_valid_o = r_q.mode_ok;
    assign ext_mode_o   = r_q.ext;
    assign ext_valid_o  = r_q.ext_ok;
    assign dll_en_o     = r_q.ext_ok & ~r_q.ext[0];
    assign viol_o       = r_q.viol;
    assign viol_cause_o = r_q.cause;
    assign iprech_o     = r_q.iprech;

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
    import ddr_cmd_pkg::*;
#(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          cke,
    input logic [3:0]    cmd_o,
    input logic [AW-1:0] mode_reg_o,
    input logic          ext_valid_o,
    input logic          dll_en_o,
    input logic          viol_o,
    input logic [2:0]    viol_cause_o
);

    assert_deselect_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !cke) |=> (cmd_o == 4'(CMD_NOP) && !viol_o));

    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_reg_o) |-> (cmd_o == 4'(CMD_MRS) && !viol_o));

    assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_cause_o == 3'(VC_MODE_BUSY)) |-> (cmd_o == 4'(CMD_MRS)));

    assert_dll_needs_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dll_en_o |-> ext_valid_o);

    assert_stop_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_cause_o == 3'(VC_BAD_STOP)) |-> (cmd_o == 4'(CMD_BST)));

    assert_clean_cmds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (cmd_o != 4'(CMD_NOP) && cmd_o != 4'(CMD_REF) && cmd_o != 4'(CMD_EMRS)));

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .cke          (cke),
    .cmd_o        (cmd_o),
    .mode_reg_o   (mode_reg_o),
    .ext_valid_o  (ext_valid_o),
    .dll_en_o     (dll_en_o),
    .viol_o       (viol_o),
    .viol_cause_o (viol_cause_o)
);

// File: tb/sim_ddr_cmd_monitor.sv
module sim_ddr_cmd_monitor;

    localparam int TRCD = 3;
    localparam int TRAS = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic [11:0] addr = 12'd0;
    logic [3:0]  cmd_o;
    logic [11:0] mode_reg_o, ext_mode_o;
    logic        mode_valid_o, ext_valid_o, dll_en_o, viol_o;
    logic [2:0]  viol_cause_o;
    logic [3:0]  iprech_o;

    int vectors = 0;
    int errors  = 0;

    always #2 clk = ~clk;

    ddr_cmd_monitor #(.TRCD(TRCD), .TRAS(TRAS), .AW(12)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_o(cmd_o),
        .mode_reg_o(mode_reg_o), .mode_valid_o(mode_valid_o),
        .ext_mode_o(ext_mode_o), .ext_valid_o(ext_valid_o), .dll_en_o(dll_en_o),
        .viol_o(viol_o), .viol_cause_o(viol_cause_o), .iprech_o(iprech_o)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                         input logic k, input logic [1:0] b, input logic [11:0] a);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = b; addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();                       drive(0,1,1,1,1,2'd0,12'd0); endtask
    task automatic act(input logic [1:0] b);    drive(0,0,1,1,1,b,12'd0);    endtask
    task automatic rd(input logic [1:0] b, input logic ap);
        drive(0,1,0,1,1,b,{1'b0,ap,10'd0});
    endtask
    task automatic wr(input logic [1:0] b);     drive(0,1,0,0,1,b,12'd0);    endtask
    task automatic pre(input logic [1:0] b);    drive(0,0,1,0,1,b,12'd0);    endtask
    task automatic prea();                      drive(0,0,1,0,1,2'd0,12'h400); endtask
    task automatic mrs(input logic [11:0] d);   drive(0,0,0,0,1,2'd0,d);     endtask
    task automatic emrs(input logic [11:0] d);  drive(0,0,0,0,1,2'd1,d);     endtask
    task automatic bst();                       drive(0,1,1,0,1,2'd0,12'd0); endtask
    task automatic refr();                      drive(0,0,0,1,1,2'd3,12'hABC); endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) nop();
    endtask

    function automatic int half_of(input int code);
        if (code == 2) return 2;
        if (code == 3) return 4;
        return 1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12 reset state
        check("R12 mode_valid", int'(mode_valid_o), 0);
        check("R12 ext_valid", int'(ext_valid_o), 0);
        check("R12 dll_en", int'(dll_en_o), 0);
        check("R12 viol", int'(viol_o), 0);
        check("R12 cmd", int'(cmd_o), 0);
        check("R12 iprech", int'(iprech_o), 0);

        // R1 decode table
        refr();      check("R1 refresh", int'(cmd_o), 3); check("R11 refresh clean", int'(viol_o), 0);
        nop();       check("R1 nop", int'(cmd_o), 0);
        act(2'd0);   check("R1 activate", int'(cmd_o), 4);
        idle(TRCD);
        rd(2'd0, 0); check("R1 read", int'(cmd_o), 5);
        wr(2'd0);    check("R1 write", int'(cmd_o), 7);
        pre(2'd0);   check("R1 precharge", int'(cmd_o), 8);
        prea();      check("R1 precharge all", int'(cmd_o), 9);
        mrs(12'h032); check("R1 mode write", int'(cmd_o), 1);
        emrs(12'h000); check("R1 ext write", int'(cmd_o), 2);
        drive(0,0,0,0,1,2'd2,12'h123); check("R1 reserved bank code", int'(cmd_o), 0);
        check("R1 reserved keeps mode", int'(mode_reg_o), 'h032);

        // R2 deselect and clock enable low
        drive(1,0,0,0,1,2'd0,12'h7FF);
        check("R2 deselect cmd", int'(cmd_o), 0);
        check("R2 deselect mode", int'(mode_reg_o), 'h032);
        check("R2 deselect viol", int'(viol_o), 0);
        drive(0,0,0,1,0,2'd0,12'd0); check("R2 cke low cmd", int'(cmd_o), 0);
        drive(1,0,1,1,1,2'd1,12'd0); check("R2 deselect act", int'(cmd_o), 0);
        idle(TRCD);
        rd(2'd1, 0); check("R2 deselected act left bank idle", int'(viol_cause_o), 5);

        // R3 mode write gating
        act(2'd2);
        mrs(12'h5A3);
        check("R3 busy cause", int'(viol_cause_o), 1);
        check("R3 busy unchanged", int'(mode_reg_o), 'h032);
        nop(); check("R11 viol clears", int'(viol_o), 0);
        check("R3 valid", int'(mode_valid_o), 1);
        // R4 extended write while a bank is open
        emrs(12'h001);
        check("R4 ext clean", int'(viol_o), 0);
        check("R4 dll off", int'(dll_en_o), 0);
        check("R4 ext value", int'(ext_mode_o), 1);
        emrs(12'h000);
        check("R4 dll on", int'(dll_en_o), 1);
        check("R4 ext valid", int'(ext_valid_o), 1);
        prea();
        mrs(12'h5A3);
        check("R3 idle accept", int'(mode_reg_o), 'h5A3);
        check("R3 idle clean", int'(viol_o), 0);

        // R5 burst stop window per burst-length code
        for (int code = 0; code < 6; code++) begin
            int h;
            h = half_of(code);
            prea();
            mrs(12'(code));
            bst(); check("R5 stop with no read", int'(viol_cause_o), 2);
            act(2'd2);
            idle(TRCD);
            for (int k = 1; k <= h + 1; k++) begin
                rd(2'd2, 0);
                idle(k - 1);
                bst();
                check("R5 stop window", int'(viol_cause_o), (k > h) ? 2 : 0);
            end
        end

        // R6 and R7: early access sweep and repeated activate
        for (int n = 1; n <= TRCD + 1; n++) begin
            prea();
            act(2'd1);
            idle(n - 1);
            rd(2'd1, 0);
            check("R7 read spacing", int'(viol_cause_o), (n < TRCD) ? 3 : 0);
        end
        for (int n = 1; n <= TRCD; n++) begin
            prea();
            act(2'd1);
            idle(n - 1);
            wr(2'd1);
            check("R7 write spacing", int'(viol_cause_o), (n < TRCD) ? 3 : 0);
        end
        rd(2'd3, 0); check("R7 idle bank read", int'(viol_cause_o), 5);
        wr(2'd0);    check("R7 idle bank write", int'(viol_cause_o), 5);
        prea();
        act(2'd1);
        idle(TRCD);
        act(2'd1); check("R6 repeat activate clean", int'(viol_o), 0);
        rd(2'd1, 0); check("R6 repeat activate ignored", int'(viol_cause_o), 0);

        // R8 internal precharge timing sweep
        for (int code = 1; code <= 3; code++) begin
            int h;
            h = half_of(code);
            prea();
            mrs(12'(code));
            for (int n = TRCD; n <= TRAS + 1; n++) begin
                int w;
                w = (h > TRAS - n) ? h : TRAS - n;
                act(2'd0);
                idle(n - 1);
                rd(2'd0, 1);
                check("R8 read-ap accepted", int'(viol_o), 0);
                check("R1 read-ap", int'(cmd_o), 6);
                for (int k = 1; k <= w; k++) begin
                    nop();
                    check("R8 precharge start edge", int'(iprech_o), (k == w) ? 1 : 0);
                end
                rd(2'd0, 0);
                check("R8 bank idle after", int'(viol_cause_o), 5);
                check("R8 single pulse", int'(iprech_o), 0);
            end
        end

        // R9 interruptions, with a coincident start edge (BL 8: w = 4 at n = TRCD)
        prea();
        mrs(12'h003);
        act(2'd3);
        idle(TRCD - 1);
        rd(2'd3, 1);
        prea();      check("R9 precharge-all blocked", int'(viol_cause_o), 4);
        rd(2'd3, 0); check("R9 read blocked", int'(viol_cause_o), 4);
        mrs(12'h002); check("R9 mode write busy", int'(viol_cause_o), 1);
        check("R9 mode unchanged", int'(mode_reg_o), 3);
        act(2'd2);
        check("R9 other bank on start edge", int'(viol_o), 0);
        check("R8 start with other command", int'(iprech_o), 8);
        rd(2'd3, 0); check("R9 bank closed after start", int'(viol_cause_o), 5);
        idle(TRCD - 1);
        rd(2'd2, 0); check("R9 other bank opened", int'(viol_cause_o), 0);

        prea();
        act(2'd3);
        idle(TRCD - 1);
        rd(2'd3, 1);
        pre(2'd3);   check("R9 precharge blocked", int'(viol_cause_o), 4);
        act(2'd3);   check("R9 activate blocked", int'(viol_cause_o), 4);
        nop();
        wr(2'd3);
        check("R9 same bank on start edge", int'(viol_cause_o), 4);
        check("R8 start with blocked command", int'(iprech_o), 8);

        // R10 precharge behaviour
        prea();
        pre(2'd1); check("R10 idle precharge clean", int'(viol_o), 0);
        act(2'd1);
        idle(TRCD);
        pre(2'd1);
        rd(2'd1, 0); check("R10 single close", int'(viol_cause_o), 5);
        act(2'd0);
        act(2'd2);
        idle(TRCD);
        prea();
        rd(2'd0, 0); check("R10 all close b0", int'(viol_cause_o), 5);
        rd(2'd2, 0); check("R10 all close b2", int'(viol_cause_o), 5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule